// File: doc/BRIEF.md
# Accumulator and Stack Register Unit

This block holds the programmer-visible registers of a small 8/16-bit accumulator processor. It has two byte accumulators, A and B, two 16-bit index registers, X and Y, and a 16-bit stack pointer. The 16-bit view D is not stored separately. It is the pair A (high byte) and B (low byte), so any write to D lands in A and B.

An external sequencer issues one command per cycle:
- load a value into a register;
- copy one register to another;
- add B into A, or subtract B from A;
- push a register onto the stack, or pull one from it.

Stack traffic goes through a byte-wide memory port. The port has an address, write data, a write strobe and read data. The read data must be valid in the same cycle as the address.

Byte stack operations take one cycle. Word stack operations take two cycles, one per byte, and hold `busy` high during the second cycle. Words are stored big-endian, so the high byte is at the lower address.

Top module: `accstack_unit`

## Requirements
- R1: After reset, A, B, X and Y read zero, SP holds the parameter SP_INIT, `busy` is low and `mem_we` is low.
- R2: Command code 1 (load) writes `cmd_data` into the register named by `cmd_reg`. Register codes are A=0, B=1, D=2, X=3, Y=4, SP=5. A byte register takes bits 7:0. D puts bits 15:8 in A and bits 7:0 in B. Register codes 6 and 7 change nothing.
- R3: Command code 2 (move) copies register `cmd_src` into register `cmd_reg`, using the register codes of R2. A byte source is zero-extended and a byte destination keeps the low byte. A source code of 6 or 7 changes nothing.
- R4: Command code 3 sets A to (A + B) mod 256 and leaves B unchanged.
- R5: Command code 4 sets A to (A − B) mod 256 and leaves B unchanged.
- R6: Command code 5 (push) with register A or B does three things in the accepting cycle: it strobes a write of that byte at address SP, decrements SP by 1, and leaves `busy` low.
- R7: A push of D, X or Y takes two cycles. The first cycle writes the low byte at SP. The second cycle writes the high byte at SP−1 with `busy` high. SP ends two lower.
- R8: Command code 6 (pull) with register A or B reads address SP+1 into that register and increments SP by 1, in one cycle.
- R9: A pull of D, X or Y reads the high byte from SP+1 and the low byte from SP+2. `busy` is high in the second cycle, and SP ends two higher.
- R10: A command presented while `busy` is high has no effect.
- R11: A push or pull that names SP or register code 6 or 7 writes no memory and leaves all registers and SP unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Command code: 0 none, 1 load, 2 move, 3 add B to A, 4 subtract B from A, 5 push, 6 pull |
| cmd_reg | input | 3 | Destination or stacked register code |
| cmd_src | input | 3 | Source register code for move |
| cmd_data | input | 16 | Value for load |
| busy | output | 1 | Second cycle of a word push or pull |
| mem_addr | output | 16 | Byte address for stack access |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write strobe |
| mem_rdata | input | 8 | Byte read from `mem_addr`, same cycle |
| reg_a | output | 8 | Accumulator A |
| reg_b | output | 8 | Accumulator B |
| reg_x | output | 16 | Index register X |
| reg_y | output | 16 | Index register Y |
| reg_sp | output | 16 | Stack pointer |

## Verification
The register path is exercised with loads of distinct high and low bytes. These separate the D alias from byte writes and show which byte a byte register keeps.

Arithmetic is tested with a sum that exactly fills a byte, one that wraps past 255, and differences that underflow. These expose carry handling and any disturbance of B.

A word is pushed and then pulled into a different register, and the stack memory is checked byte by byte. This confirms the write order, the big-endian placement and the SP step sizes.

Finally, a load is held on the inputs through the busy cycle, and pushes of SP or of an undefined code are issued. Both must leave every register and SP as they were.

// File: rtl/accstack_pkg.sv
package accstack_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_LOAD  = 3'd1,
        OP_MOVE  = 3'd2,
        OP_ADDBA = 3'd3,
        OP_SUBBA = 3'd4,
        OP_PUSH  = 3'd5,
        OP_PULL  = 3'd6
    } op_e;

    typedef enum logic [2:0] {
        SEL_A  = 3'd0,
        SEL_B  = 3'd1,
        SEL_D  = 3'd2,
        SEL_X  = 3'd3,
        SEL_Y  = 3'd4,
        SEL_SP = 3'd5
    } sel_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_PUSH_HI,
        PH_PULL_LO
    } phase_e;

    typedef struct packed {
        logic [BYTE_W-1:0] a;
        logic [BYTE_W-1:0] b;
        logic [WORD_W-1:0] x;
        logic [WORD_W-1:0] y;
        logic [WORD_W-1:0] sp;
        phase_e            phase;
        sel_e              sel;
    } state_t;

endpackage

// File: rtl/accstack_rdmux.sv
module accstack_rdmux
    import accstack_pkg::*;
(
    input  logic [BYTE_W-1:0] a_i,
    input  logic [BYTE_W-1:0] b_i,
    input  logic [WORD_W-1:0] x_i,
    input  logic [WORD_W-1:0] y_i,
    input  logic [WORD_W-1:0] sp_i,
    input  logic [2:0]        sel_i,
    output logic [WORD_W-1:0] view_o,
    output logic              is_byte_o,
    output logic              is_word_o
);

    localparam logic [BYTE_W-1:0] ZERO_B = '0;

    // 16-bit view of the selected register; byte registers are zero-extended
    always_comb begin
        view_o    = '0;
        is_byte_o = 1'b0;
        is_word_o = 1'b0;
        case (sel_e'(sel_i))
            SEL_A:   begin view_o = {ZERO_B, a_i}; is_byte_o = 1'b1; end
            SEL_B:   begin view_o = {ZERO_B, b_i}; is_byte_o = 1'b1; end
            SEL_D:   begin view_o = {a_i, b_i};    is_word_o = 1'b1; end
            SEL_X:   begin view_o = x_i;           is_word_o = 1'b1; end
            SEL_Y:   begin view_o = y_i;           is_word_o = 1'b1; end
            SEL_SP:  view_o = sp_i;
            default: view_o = '0;
        endcase
    end

endmodule

// File: rtl/accstack_alu.sv
module accstack_alu
    import accstack_pkg::*;
(
    input  logic [BYTE_W-1:0] a_i,
    input  logic [BYTE_W-1:0] b_i,
    input  logic              sub_i,
    output logic [BYTE_W-1:0] res_o
);

    always_comb begin
        res_o = sub_i ? (a_i - b_i) : (a_i + b_i);
    end

endmodule

// File: rtl/accstack_unit.sv
module accstack_unit
    import accstack_pkg::*;
#(
    parameter logic [WORD_W-1:0] SP_INIT = 16'h00F0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [2:0]        cmd_reg,
    input  logic [2:0]        cmd_src,
    input  logic [WORD_W-1:0] cmd_data,
    output logic              busy,
    output logic [WORD_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [BYTE_W-1:0] reg_a,
    output logic [BYTE_W-1:0] reg_b,
    output logic [WORD_W-1:0] reg_x,
    output logic [WORD_W-1:0] reg_y,
    output logic [WORD_W-1:0] reg_sp
);

    localparam logic [WORD_W-1:0] STEP   = 1;
    localparam logic [BYTE_W-1:0] ZERO_B = '0;
    localparam logic [2:0]        LAST_SEL = 3'(SEL_SP);

    state_t state_q, state_d;

    logic [2:0]        prim_sel;
    logic [WORD_W-1:0] prim_view, src_view;
    logic              prim_byte, prim_word;
    logic              src_byte_unused, src_word_unused;
    logic [BYTE_W-1:0] alu_res;
    logic              alu_sub;

    // Write one register (or the A:B pair) in a state copy
    function automatic state_t put_reg(state_t s, logic [2:0] sel, logic [WORD_W-1:0] w);
        state_t r;
        r = s;
        case (sel_e'(sel))
            SEL_A:   r.a  = w[BYTE_W-1:0];
            SEL_B:   r.b  = w[BYTE_W-1:0];
            SEL_D:   begin r.a = w[WORD_W-1:BYTE_W]; r.b = w[BYTE_W-1:0]; end
            SEL_X:   r.x  = w;
            SEL_Y:   r.y  = w;
            SEL_SP:  r.sp = w;
            default: r = s;
        endcase
        return r;
    endfunction

    // During the second byte of a word op the latched selector drives the port
    assign prim_sel = (state_q.phase == PH_IDLE) ? cmd_reg : 3'(state_q.sel);
    assign alu_sub  = (cmd_op == 3'(OP_SUBBA));

    accstack_rdmux u_rd_prim (
        .a_i      (state_q.a),
        .b_i      (state_q.b),
        .x_i      (state_q.x),
        .y_i      (state_q.y),
        .sp_i     (state_q.sp),
        .sel_i    (prim_sel),
        .view_o   (prim_view),
        .is_byte_o(prim_byte),
        .is_word_o(prim_word)
    );

    accstack_rdmux u_rd_src (
        .a_i      (state_q.a),
        .b_i      (state_q.b),
        .x_i      (state_q.x),
        .y_i      (state_q.y),
        .sp_i     (state_q.sp),
        .sel_i    (cmd_src),
        .view_o   (src_view),
        .is_byte_o(src_byte_unused),
        .is_word_o(src_word_unused)
    );

    accstack_alu u_alu (
        .a_i  (state_q.a),
        .b_i  (state_q.b),
        .sub_i(alu_sub),
        .res_o(alu_res)
    );

    always_comb begin
        state_d   = state_q;
        mem_addr  = state_q.sp;
        mem_wdata = '0;
        mem_we    = 1'b0;
        case (state_q.phase)
            PH_IDLE: begin
                if (cmd_valid) begin
                    case (op_e'(cmd_op))
                        OP_LOAD: state_d = put_reg(state_q, cmd_reg, cmd_data);
                        OP_MOVE: begin
                            if (cmd_src <= LAST_SEL) begin
                                state_d = put_reg(state_q, cmd_reg, src_view);
                            end
                        end
                        OP_ADDBA, OP_SUBBA: state_d.a = alu_res;
                        OP_PUSH: begin
                            if (prim_byte || prim_word) begin
                                mem_we     = 1'b1;
                                mem_wdata  = prim_view[BYTE_W-1:0];
                                state_d.sp = state_q.sp - STEP;
                                if (prim_word) begin
                                    state_d.phase = PH_PUSH_HI;
                                    state_d.sel   = sel_e'(cmd_reg);
                                end
                            end
                        end
                        OP_PULL: begin
                            mem_addr = state_q.sp + STEP;
                            if (prim_byte) begin
                                state_d    = put_reg(state_q, cmd_reg, {ZERO_B, mem_rdata});
                                state_d.sp = state_q.sp + STEP;
                            end else if (prim_word) begin
                                state_d       = put_reg(state_q, cmd_reg,
                                                        {mem_rdata, prim_view[BYTE_W-1:0]});
                                state_d.sp    = state_q.sp + STEP;
                                state_d.phase = PH_PULL_LO;
                                state_d.sel   = sel_e'(cmd_reg);
                            end
                        end
                        default: state_d = state_q;
                    endcase
                end
            end
            PH_PUSH_HI: begin
                mem_we        = 1'b1;
                mem_wdata     = prim_view[WORD_W-1:BYTE_W];
                state_d.sp    = state_q.sp - STEP;
                state_d.phase = PH_IDLE;
            end
            PH_PULL_LO: begin
                mem_addr      = state_q.sp + STEP;
                state_d       = put_reg(state_q, 3'(state_q.sel),
                                        {prim_view[WORD_W-1:BYTE_W], mem_rdata});
                state_d.sp    = state_q.sp + STEP;
                state_d.phase = PH_IDLE;
            end
            default: state_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{a: '0, b: '0, x: '0, y: '0, sp: SP_INIT,
                         phase: PH_IDLE, sel: SEL_A};
        end else begin
            state_q <= state_d;
        end
    end

    assign busy   = (state_q.phase != PH_IDLE);
    assign reg_a  = state_q.a;
    assign reg_b  = state_q.b;
    assign reg_x  = state_q.x;
    assign reg_y  = state_q.y;
    assign reg_sp = state_q.sp;

endmodule

// File: rtl/accstack_chk.sv
module accstack_chk
    import accstack_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic [2:0]        cmd_reg,
    input logic              busy,
    input logic              mem_we,
    input logic [WORD_W-1:0] mem_addr,
    input logic [BYTE_W-1:0] reg_a,
    input logic [BYTE_W-1:0] reg_b,
    input logic [WORD_W-1:0] reg_sp
);

    logic taken;
    assign taken = cmd_valid && !busy;

    AST_ADD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && cmd_op == 3'd3) |=> (reg_a == 8'($past(reg_a) + $past(reg_b)))); // R4

    AST_SUB_KEEPS_B: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && cmd_op == 3'd4) |=> $stable(reg_b)); // R5

    AST_BYTE_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && cmd_op == 3'd5 && cmd_reg <= 3'd1) |=>
            ((reg_sp == $past(reg_sp) - 16'd1) && !busy)); // R6

    AST_WRITE_AT_SP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == reg_sp)); // R6

    AST_WORD_PUSH_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && cmd_op == 3'd5 && cmd_reg >= 3'd2 && cmd_reg <= 3'd4) |=>
            (busy && mem_we)); // R7

    AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy); // R10

    AST_BAD_PUSH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && cmd_op == 3'd5 && cmd_reg >= 3'd5) |-> !mem_we); // R11

endmodule

bind accstack_unit accstack_chk u_chk (.*);

// File: tb/tb_accstack_unit.sv
module tb_accstack_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0, cmd_reg = '0, cmd_src = '0;
    logic [15:0] cmd_data = '0;
    logic        busy, mem_we;
    logic [15:0] mem_addr, reg_x, reg_y, reg_sp;
    logic [7:0]  mem_wdata, mem_rdata, reg_a, reg_b;

    always #10 clk = ~clk;

    accstack_unit dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_reg(cmd_reg), .cmd_src(cmd_src), .cmd_data(cmd_data), .busy(busy),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .reg_a(reg_a), .reg_b(reg_b), .reg_x(reg_x),
        .reg_y(reg_y), .reg_sp(reg_sp)
    );

    logic [7:0] mem [256];
    logic [7:0] emem [256];
    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

    logic [7:0]  ea = 8'h00, eb = 8'h00;
    logic [15:0] ex = 16'h0, ey = 16'h0, esp = 16'h00F0;

    typedef struct {
        logic [7:0]  a, b;
        logic [15:0] x, y, sp;
        string       req;
    } exp_t;
    exp_t sb[$];

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mview(logic [2:0] sel);
        case (sel)
            3'd0: return {8'h00, ea};
            3'd1: return {8'h00, eb};
            3'd2: return {ea, eb};
            3'd3: return ex;
            3'd4: return ey;
            3'd5: return esp;
            default: return 16'h0;
        endcase
    endfunction

    task automatic mput(logic [2:0] sel, logic [15:0] w);
        case (sel)
            3'd0: ea = w[7:0];
            3'd1: eb = w[7:0];
            3'd2: begin ea = w[15:8]; eb = w[7:0]; end
            3'd3: ex = w;
            3'd4: ey = w;
            3'd5: esp = w;
            default: ;
        endcase
    endtask

    // Reference model update from the requirements
    task automatic model(logic [2:0] op, logic [2:0] sel, logic [2:0] src, logic [15:0] data);
        logic [15:0] w;
        logic [7:0]  p;
        p = esp[7:0];
        case (op)
            3'd1: mput(sel, data);
            3'd2: if (src <= 3'd5) mput(sel, mview(src));
            3'd3: ea = ea + eb;
            3'd4: ea = ea - eb;
            3'd5: begin
                if (sel <= 3'd1) begin
                    w = mview(sel); emem[p] = w[7:0]; esp = esp - 16'd1;
                end else if (sel <= 3'd4) begin
                    w = mview(sel); emem[p] = w[7:0]; emem[p - 8'd1] = w[15:8];
                    esp = esp - 16'd2;
                end
            end
            3'd6: begin
                if (sel <= 3'd1) begin
                    mput(sel, {8'h00, emem[p + 8'd1]}); esp = esp + 16'd1;
                end else if (sel <= 3'd4) begin
                    mput(sel, {emem[p + 8'd1], emem[p + 8'd2]}); esp = esp + 16'd2;
                end
            end
            default: ;
        endcase
    endtask

    task automatic push_exp(string req);
        exp_t e;
        e.a = ea; e.b = eb; e.x = ex; e.y = ey; e.sp = esp; e.req = req;
        sb.push_back(e);
    endtask

    // Driver: issue one command, track the busy cycle, queue expected state
    task automatic issue(logic [2:0] op, logic [2:0] sel, logic [2:0] src,
                         logic [15:0] data, string req);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_reg = sel; cmd_src = src; cmd_data = data;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        if ((op == 3'd5 || op == 3'd6) && sel >= 3'd2 && sel <= 3'd4) begin
            check(req, "busy in second cycle", {15'h0, busy}, 16'h1);
            @(posedge clk); #1;
        end
        check(req, "busy after command", {15'h0, busy}, 16'h0);
        model(op, sel, src, data);
        push_exp(req);
    endtask

    task automatic mem_check(string req, logic [7:0] addr);
        @(negedge clk);
        check(req, "stack byte", {8'h00, mem[addr]}, {8'h00, emem[addr]});
    endtask

    // Monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin
        exp_t e;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            check(e.req, "A",  {8'h00, reg_a}, {8'h00, e.a});
            check(e.req, "B",  {8'h00, reg_b}, {8'h00, e.b});
            check(e.req, "X",  reg_x,  e.x);
            check(e.req, "Y",  reg_y,  e.y);
            check(e.req, "SP", reg_sp, e.sp);
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'h00; emem[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "A", {8'h00, reg_a}, 16'h0);
        check("R1", "B", {8'h00, reg_b}, 16'h0);
        check("R1", "X", reg_x, 16'h0);
        check("R1", "Y", reg_y, 16'h0);
        check("R1", "SP", reg_sp, 16'h00F0);
        check("R1", "busy", {15'h0, busy}, 16'h0);
        check("R1", "we", {15'h0, mem_we}, 16'h0);

        // R2 loads
        issue(3'd1, 3'd0, 3'd0, 16'h1234, "R2");
        issue(3'd1, 3'd1, 3'd0, 16'h99FF, "R2");
        issue(3'd1, 3'd2, 3'd0, 16'hA55A, "R2");
        issue(3'd1, 3'd3, 3'd0, 16'h1357, "R2");
        issue(3'd1, 3'd4, 3'd0, 16'hBEEF, "R2");
        issue(3'd1, 3'd6, 3'd0, 16'hFFFF, "R2");

        // R4 / R5 arithmetic
        issue(3'd3, 3'd0, 3'd0, 16'h0, "R4");
        issue(3'd1, 3'd1, 3'd0, 16'h0002, "R2");
        issue(3'd3, 3'd0, 3'd0, 16'h0, "R4");
        issue(3'd4, 3'd0, 3'd0, 16'h0, "R5");
        issue(3'd4, 3'd0, 3'd0, 16'h0, "R5");

        // R3 moves
        issue(3'd2, 3'd3, 3'd2, 16'h0, "R3");
        issue(3'd2, 3'd0, 3'd4, 16'h0, "R3");
        issue(3'd2, 3'd2, 3'd1, 16'h0, "R3");
        issue(3'd2, 3'd4, 3'd7, 16'h0, "R3");
        issue(3'd1, 3'd0, 3'd0, 16'h00C3, "R2");

        // R6 byte push, R7 word push
        issue(3'd5, 3'd0, 3'd0, 16'h0, "R6");
        mem_check("R6", 8'hF0);
        issue(3'd5, 3'd3, 3'd0, 16'h0, "R7");
        mem_check("R7", 8'hEF);
        mem_check("R7", 8'hEE);

        // R9 word pull into Y, R8 byte pull into B
        issue(3'd6, 3'd4, 3'd0, 16'h0, "R9");
        issue(3'd6, 3'd1, 3'd0, 16'h0, "R8");

        // R10: a load held through the busy cycle of a word push
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd5; cmd_reg = 3'd2;
        @(posedge clk); #1;
        cmd_op = 3'd1; cmd_reg = 3'd0; cmd_data = 16'h0055;
        check("R10", "busy", {15'h0, busy}, 16'h1);
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        model(3'd5, 3'd2, 3'd0, 16'h0);
        push_exp("R10");
        mem_check("R10", 8'hEF);
        mem_check("R10", 8'hF0);

        // R11: push/pull naming SP or undefined codes
        issue(3'd5, 3'd5, 3'd0, 16'h0, "R11");
        issue(3'd5, 3'd7, 3'd0, 16'h0, "R11");
        issue(3'd6, 3'd6, 3'd0, 16'h0, "R11");
        mem_check("R11", 8'hEE);

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule